// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block sends a stream of 24-bit stereo sample pairs over one serial data line. The line is framed by a bit clock and a word clock whose level tells which channel is on the line. A static format input selects either I2S framing or left-justified framing. The same shift engine serves both.

The clocking side is fixed once, on the first clock after reset releases. In master mode the block makes its bit clock and word clock from two single-cycle enables that a clock generator supplies. A frame then spans 64 bit periods. In slave mode the block takes a bit clock and a word clock from outside. It brings them into its own clock domain with a synchronizer, steps its frame position on each falling bit-clock edge it detects, and snaps that position to the start of a channel whenever the word clock changes level.

Samples come in through a valid/ready handshake into a one-entry holding register. A pair waiting there is moved into the transmit register at the start of the next frame. When no pair is waiting, the previous pair goes out again.

Top module: `audio_ser_tx`

## Requirements
- R1: With `fmt_i` = 0 (I2S), the left word goes out while the word clock is low and the right word while it is high. The MSB of each word sits in the second bit slot after the word-clock change, which is one bit period late.
- R2: With `fmt_i` = 1 (left-justified), the left word goes out while the word clock is high and the right word while it is low. The MSB of each word sits in the first bit slot after the word-clock change.
- R3: The data line changes only in response to a falling bit-clock edge. In master mode it changes on the clock after a cycle with `bclk_fall_en_i` high, and it holds its value in every other cycle.
- R4: Each channel has 32 bit slots. A word is sent two's-complement MSB first in 24 consecutive slots, and the 8 slots that follow it are driven low.
- R5: In master mode `bclk_o` goes high on the clock after `bclk_rise_en_i` and low on the clock after `bclk_fall_en_i`. `lrck_o` changes only on falling bit-clock steps and toggles every 32 of them, so a frame is 64 bit periods. The two enables are never high in the same cycle.
- R6: `smp_ready_o` is high while the holding register is empty. A pair presented with `smp_valid_i` high while ready is high is taken, and ready then drops. The taken pair first goes out in the frame whose start comes after the take. A pair taken in the very cycle a frame starts waits for the following frame.
- R7: If no pair is waiting when a frame starts, the previous pair is sent again unchanged.
- R8: `master_i` is sampled on the first clock after reset releases (1 = master, 0 = slave). Later changes of `master_i` have no effect until the next reset.
- R9: In slave mode the block follows `bclk_i` and `lrck_i` through a two-stage synchronizer. On the first falling bit-clock edge at which the word-clock level differs from its level at the previous falling edge, the frame position is set to the start of the channel that the new level selects. `bclk_o` and `lrck_o` stay low in slave mode.
- R10: After reset, before any bit-clock step, `sdata_o` and `bclk_o` are low and `smp_ready_o` is high. In master mode `lrck_o` shows the last slot of a frame: high for I2S, low for left-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 1 | Framing select: 0 I2S, 1 left-justified; static |
| master_i | input | 1 | Clocking select sampled after reset: 1 master, 0 slave |
| bclk_fall_en_i | input | 1 | Master mode: falling bit-clock step enable |
| bclk_rise_en_i | input | 1 | Master mode: rising bit-clock step enable |
| bclk_i | input | 1 | Slave mode: external bit clock |
| lrck_i | input | 1 | Slave mode: external word clock |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_left_i | input | DATA_W | Left sample, two's complement |
| smp_right_i | input | DATA_W | Right sample, two's complement |
| smp_ready_o | output | 1 | Holding register empty, pair can be taken |
| bclk_o | output | 1 | Master mode bit clock |
| lrck_o | output | 1 | Master mode word clock |
| sdata_o | output | 1 | Serial data line |

## Verification
The interesting collision is a pair being taken into the holding register in the same cycle that a falling bit-clock step starts a new frame. The bench waits until its model is at the last slot of a frame with a falling enable due on the next edge. It then presents a pair in exactly that cycle. It judges the result by the ready line dropping and by the model expecting the new pair in the frame after the one just started, while the line keeps the old pair for one more frame. A second collision is the word-clock change and the falling bit-clock edge arriving together in slave mode. This is provoked by changing both inputs on the same clock, and it is judged by decoding whole frames taken at the rising bit-clock edges.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } ser_fmt_e;
endpackage

// File: rtl/ser_clk_ctrl.sv
module ser_clk_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic bclk_fall_en_i,
  input  logic bclk_rise_en_i,
  input  logic bclk_i,
  input  logic lrck_i,
  output logic master_o,
  output logic mode_done_o,
  output logic fall_ev_o,
  output logic lr_lvl_o,
  output logic bclk_o
);
  logic                   mode_done_q, master_q;
  logic [SYNC_STAGES-1:0] bclk_sync_q, lrck_sync_q;
  logic                   bclk_prev_q, m_bclk_q;
  logic                   s_fall;

  // clocking choice frozen on first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_done_q <= 1'b0;
      master_q    <= 1'b0;
    end else if (!mode_done_q) begin
      mode_done_q <= 1'b1;
      master_q    <= master_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_sync_q <= '0;
      lrck_sync_q <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      bclk_sync_q <= {bclk_sync_q[SYNC_STAGES-2:0], bclk_i};
      lrck_sync_q <= {lrck_sync_q[SYNC_STAGES-2:0], lrck_i};
      bclk_prev_q <= bclk_sync_q[SYNC_STAGES-1];
    end
  end

  assign s_fall = bclk_prev_q & ~bclk_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        m_bclk_q <= 1'b0;
    else if (mode_done_q && master_q) begin
      if (bclk_fall_en_i)               m_bclk_q <= 1'b0;
      else if (bclk_rise_en_i)          m_bclk_q <= 1'b1;
    end
  end

  assign fall_ev_o   = mode_done_q & (master_q ? bclk_fall_en_i : s_fall);
  assign lr_lvl_o    = lrck_sync_q[SYNC_STAGES-1];
  assign master_o    = master_q;
  assign mode_done_o = mode_done_q;
  assign bclk_o      = m_bclk_q;
endmodule

// File: rtl/ser_frame_ctr.sv
module ser_frame_ctr
  import audio_ser_pkg::*;
#(
  parameter  int unsigned SLOT_W = 32,
  localparam int unsigned CNT_W  = $clog2(2 * SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_ev_i,
  input  logic             master_i,
  input  ser_fmt_e         fmt_i,
  input  logic             lr_lvl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_cnt_o,
  output logic             frame_start_o,
  output logic             lrck_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(SLOT_W);

  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             lr_prev_q, left_lvl;

  assign left_lvl = (fmt_i == FMT_LJ);

  always_comb begin
    if (!master_i && (lr_lvl_i != lr_prev_q))
      nxt_cnt = (lr_lvl_i == left_lvl) ? '0 : HALF;  // realign on word edge
    else
      nxt_cnt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      lr_prev_q <= 1'b0;
    end else if (fall_ev_i) begin
      cnt_q <= nxt_cnt;
      if (!master_i) lr_prev_q <= lr_lvl_i;
    end
  end

  assign cnt_o         = cnt_q;
  assign nxt_cnt_o     = nxt_cnt;
  assign frame_start_o = fall_ev_i && (nxt_cnt == '0);
  assign lrck_o        = master_i & (cnt_q[CNT_W-1] ^ left_lvl);
endmodule

// File: rtl/ser_sample_buf.sv
module ser_sample_buf #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              ready_o,
  input  logic              frame_start_i,
  output logic [DATA_W-1:0] nxt_left_o,
  output logic [DATA_W-1:0] nxt_right_o
);
  logic [DATA_W-1:0] hold_l_q, hold_r_q, act_l_q, act_r_q;
  logic              full_q, load, accept;

  assign accept = valid_i && !full_q;
  assign load   = frame_start_i && full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      full_q   <= 1'b0;
    end else if (accept) begin
      hold_l_q <= left_i;
      hold_r_q <= right_i;
      full_q   <= 1'b1;
    end else if (load) begin
      full_q   <= 1'b0;
    end
  end

  assign nxt_left_o  = load ? hold_l_q : act_l_q;
  assign nxt_right_o = load ? hold_r_q : act_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_l_q <= '0;
      act_r_q <= '0;
    end else begin
      act_l_q <= nxt_left_o;
      act_r_q <= nxt_right_o;
    end
  end

  assign ready_o = !full_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import audio_ser_pkg::*;
#(
  parameter  int unsigned DATA_W     = 24,
  parameter  int unsigned SLOT_W     = 32,
  localparam int unsigned SLOT_IDX_W = $clog2(SLOT_W),
  localparam int unsigned CNT_W      = SLOT_IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_ev_i,
  input  ser_fmt_e          fmt_i,
  input  logic [CNT_W-1:0]  nxt_cnt_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              sdata_o
);
  logic [CNT_W-1:0]  pos;
  logic [DATA_W-1:0] word;
  logic [SLOT_W-1:0] slot_bits;
  logic              sdata_q;

  // I2S data trails the word clock by one slot
  assign pos  = (fmt_i == FMT_LJ) ? nxt_cnt_i : nxt_cnt_i - CNT_W'(1);
  assign word = pos[CNT_W-1] ? right_i : left_i;

  for (genvar g = 0; g < SLOT_W; g++) begin : g_slot
    if (g < DATA_W) begin : g_data
      assign slot_bits[g] = word[DATA_W-1-g];
    end else begin : g_pad
      assign slot_bits[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sdata_q <= 1'b0;
    else if (fall_ev_i) sdata_q <= slot_bits[pos[SLOT_IDX_W-1:0]];
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter  int unsigned DATA_W      = 24,
  parameter  int unsigned SLOT_W      = 32,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W       = $clog2(2 * SLOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              master_i,
  input  logic              bclk_fall_en_i,
  input  logic              bclk_rise_en_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              smp_ready_o,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              sdata_o
);
  ser_fmt_e          fmt;
  logic              master_w, mode_done_w, fall_ev, lr_lvl, frame_start;
  logic [CNT_W-1:0]  cnt_w, nxt_cnt;
  logic [DATA_W-1:0] nxt_l, nxt_r;

  assign fmt = ser_fmt_e'(fmt_i);

  ser_clk_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_clk_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .master_i       (master_i),
    .bclk_fall_en_i (bclk_fall_en_i),
    .bclk_rise_en_i (bclk_rise_en_i),
    .bclk_i         (bclk_i),
    .lrck_i         (lrck_i),
    .master_o       (master_w),
    .mode_done_o    (mode_done_w),
    .fall_ev_o      (fall_ev),
    .lr_lvl_o       (lr_lvl),
    .bclk_o         (bclk_o)
  );

  ser_frame_ctr #(.SLOT_W(SLOT_W)) i_frame_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fall_ev_i     (fall_ev),
    .master_i      (master_w),
    .fmt_i         (fmt),
    .lr_lvl_i      (lr_lvl),
    .cnt_o         (cnt_w),
    .nxt_cnt_o     (nxt_cnt),
    .frame_start_o (frame_start),
    .lrck_o        (lrck_o)
  );

  ser_sample_buf #(.DATA_W(DATA_W)) i_sample_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (smp_valid_i),
    .left_i        (smp_left_i),
    .right_i       (smp_right_i),
    .ready_o       (smp_ready_o),
    .frame_start_i (frame_start),
    .nxt_left_o    (nxt_l),
    .nxt_right_o   (nxt_r)
  );

  ser_shift #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_ev_i (fall_ev),
    .fmt_i     (fmt),
    .nxt_cnt_i (nxt_cnt),
    .left_i    (nxt_l),
    .right_i   (nxt_r),
    .sdata_o   (sdata_o)
  );
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter  int unsigned DATA_W     = 24,
  parameter  int unsigned SLOT_W     = 32,
  localparam int unsigned SLOT_IDX_W = $clog2(SLOT_W),
  localparam int unsigned CNT_W      = SLOT_IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fmt_i,
  input logic             bclk_fall_en_i,
  input logic             bclk_rise_en_i,
  input logic             smp_valid_i,
  input logic             smp_ready_o,
  input logic             bclk_o,
  input logic             lrck_o,
  input logic             sdata_o,
  input logic             master_w,
  input logic             mode_done_w,
  input logic [CNT_W-1:0] cnt_w
);
  logic [CNT_W-1:0] pos_c;
  logic             pad_c;

  assign pos_c = fmt_i ? cnt_w : cnt_w - CNT_W'(1);
  assign pad_c = (int'(pos_c[SLOT_IDX_W-1:0]) >= int'(DATA_W));

  assert_chan_lrck_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_w && !pad_c) |-> (lrck_o == (pos_c[CNT_W-1] ^ fmt_i)));

  assert_sdata_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_w && !$stable(sdata_o)) |-> $past(bclk_fall_en_i));

  assert_pad_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_c |-> !sdata_o);

  assert_bclk_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_w && $rose(bclk_o)) |-> $past(bclk_rise_en_i));

  assert_lrck_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_w && $past(master_w) && !$stable(lrck_o)) |-> $past(bclk_fall_en_i));

  assert_take_drops_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

  assert_mode_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_done_w |=> $stable(master_w));

  assert_slave_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_w |-> (!bclk_o && !lrck_o));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fmt_i          (fmt_i),
  .bclk_fall_en_i (bclk_fall_en_i),
  .bclk_rise_en_i (bclk_rise_en_i),
  .smp_valid_i    (smp_valid_i),
  .smp_ready_o    (smp_ready_o),
  .bclk_o         (bclk_o),
  .lrck_o         (lrck_o),
  .sdata_o        (sdata_o),
  .master_w       (master_w),
  .mode_done_w    (mode_done_w),
  .cnt_w          (cnt_w)
);

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
  logic        clk = 1'b0, rst_ni = 1'b0, fmt = 1'b0, master = 1'b1;
  logic        fall_en = 1'b0, rise_en = 1'b0, bclk_in = 1'b0, lrck_in = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] l_in = '0, r_in = '0;
  logic        smp_ready, bclk_out, lrck_out, sdata;

  int    n_run = 0, n_fail = 0, ph = 0;
  bit    cmp_on = 1'b0, en_run = 1'b0;
  string ph_tag = "";

  // reference model state
  int          m_cnt = 63;
  bit          m_started, m_master, m_bclk, m_sd, m_fell, was_empty, fe, re;
  logic [47:0] hold[$];
  logic [23:0] m_l, m_r;
  logic        prev_sd = 1'b0;

  audio_ser_tx i_audio_ser_tx (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt), .master_i(master),
    .bclk_fall_en_i(fall_en), .bclk_rise_en_i(rise_en),
    .bclk_i(bclk_in), .lrck_i(lrck_in),
    .smp_valid_i(valid), .smp_left_i(l_in), .smp_right_i(r_in),
    .smp_ready_o(smp_ready), .bclk_o(bclk_out), .lrck_o(lrck_out), .sdata_o(sdata)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(int cnt, bit f, logic [23:0] l, logic [23:0] r);
    int pos = f ? cnt : (cnt + 63) % 64;
    int s = pos % 32;
    if (s >= 24) return 1'b0;
    return (pos >= 32) ? r[23-s] : l[23-s];
  endfunction

  // clock generator enables: fall at phase 0, rise at phase 2
  always @(negedge clk) begin
    fall_en <= en_run && (ph == 0);
    rise_en <= en_run && (ph == 2);
    ph      <= (ph + 1) % 4;
  end

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_started = 0; m_master = 0; m_cnt = 63; m_bclk = 0; m_sd = 0; m_fell = 0;
      m_l = '0; m_r = '0; hold.delete();
    end else begin
      was_empty = (hold.size() == 0);
      fe = m_started && m_master && fall_en;
      re = m_started && m_master && rise_en;
      if (!m_started) begin m_started = 1; m_master = master; end
      m_fell = fe;
      if (fe) begin
        m_cnt = (m_cnt + 1) % 64;
        if (m_cnt == 0 && !was_empty) {m_l, m_r} = hold.pop_front();
        m_sd = exp_bit(m_cnt, fmt, m_l, m_r);
        m_bclk = 0;
      end else if (re) m_bclk = 1;
      if (was_empty && valid) hold.push_back({l_in, r_in});
    end
  end

  always @(negedge clk) begin : cmp_blk
    int    pos;
    string t;
    if (cmp_on && rst_ni) begin
      pos = fmt ? m_cnt : (m_cnt + 63) % 64;
      t = (ph_tag != "") ? ph_tag : ((pos % 32 >= 24) ? "R4" : (fmt ? "R2" : "R1"));
      chk(t, 32'(sdata), 32'(m_sd));
      if (!m_fell) chk("R3", 32'(sdata), 32'(prev_sd));
      prev_sd = sdata;
      chk("R5", 32'(bclk_out), 32'(m_bclk));
      chk("R5", 32'(lrck_out), 32'(m_master ? (fmt ? (m_cnt < 32) : (m_cnt >= 32)) : 1'b0));
      chk("R6", 32'(smp_ready), 32'(hold.size() == 0));
    end
  end

  task automatic do_reset(bit f, bit m);
    cmp_on = 0; en_run = 0; valid = 0; bclk_in = 0; lrck_in = 0;
    rst_ni = 0; fmt = f; master = m; prev_sd = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk); #1;
    chk("R10", 32'(sdata), 0);
    chk("R10", 32'(bclk_out), 0);
    chk("R10", 32'(smp_ready), 1);
    chk("R10", 32'(lrck_out), 32'(m ? !f : 1'b0));
    cmp_on = m;
  endtask

  task automatic push(logic [23:0] l, logic [23:0] r);
    @(negedge clk); #1;
    while (!smp_ready) begin @(negedge clk); #1; end
    valid = 1; l_in = l; r_in = r;
    @(negedge clk);
    valid = 0;
  endtask

  task automatic run_master(bit f);
    do_reset(f, 1'b1);
    en_run = 1;
    push(24'h800001, 24'h7FFFFE);
    repeat (512) @(negedge clk);
    push(24'hA5C3F1, 24'h0F0F0F);
    repeat (256) @(negedge clk);
    ph_tag = "R7";
    repeat (512) @(negedge clk);
    ph_tag = "R8";
    master = 0;
    repeat (256) @(negedge clk);
    master = 1;
    ph_tag = "R6";
    @(negedge clk); #1;
    while (!(m_cnt == 63 && fall_en && smp_ready)) begin @(negedge clk); #1; end
    valid = 1; l_in = 24'h123456; r_in = 24'hFEDCBA;
    @(negedge clk);
    valid = 0; #1;
    chk("R6", 32'(smp_ready), 0);
    repeat (512) @(negedge clk);
    ph_tag = "";
    en_run = 0;
  endtask

  task automatic sl_slot(bit lv, output logic got);
    bclk_in = 0; lrck_in = lv;
    repeat (6) @(negedge clk);
    bclk_in = 1; got = sdata;
    repeat (6) @(negedge clk);
  endtask

  task automatic sl_frame(bit f, logic [23:0] el, logic [23:0] er, bit do_chk);
    logic [23:0] gl, gr;
    logic        got;
    gl = '0; gr = '0;
    for (int s = 0; s < 64; s++) begin
      int k = (s % 32) - (f ? 0 : 1);
      bit e;
      sl_slot((s < 32) ? f : !f, got);
      e = (k >= 0 && k < 24) ? ((s >= 32) ? er[23-k] : el[23-k]) : 1'b0;
      if (k >= 0 && k < 24) begin
        if (s >= 32) gr[23-k] = got; else gl[23-k] = got;
      end
      if (do_chk) chk((k >= 0 && k < 24) ? (f ? "R2" : "R1") : "R4", 32'(got), 32'(e));
    end
    if (do_chk) begin
      chk("R9", 32'(gl), 32'(el));
      chk("R9", 32'(gr), 32'(er));
    end
  endtask

  task automatic run_slave(bit f);
    logic junk;
    do_reset(f, 1'b0);
    chk("R9", 32'(bclk_out), 0);
    chk("R9", 32'(lrck_out), 0);
    push(24'hC00003, 24'h3FFFFC);
    for (int s = 0; s < 20; s++) sl_slot(!f, junk);
    sl_frame(f, 24'h0, 24'h0, 1'b0);
    sl_frame(f, 24'hC00003, 24'h3FFFFC, 1'b1);
    push(24'h5A5A5A, 24'h96E1D2);
    sl_frame(f, 24'h5A5A5A, 24'h96E1D2, 1'b1);
    sl_frame(f, 24'h5A5A5A, 24'h96E1D2, 1'b1);
    chk("R9", 32'(bclk_out), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R5: watchdog expired, actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    run_master(1'b0);
    run_master(1'b1);
    run_slave(1'b0);
    run_slave(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule